// File: doc/BRIEF.md
# UART modem status register

This block holds the modem-side half of a 16550-style serial port's status. It watches four active-low handshake pins: clear-to-send, data-set-ready, ring indicator and carrier detect. The upper four bits of the status byte show their current, inverted levels. The lower four bits are sticky change flags that a CPU read clears. While any flag is set and the enable input is high, the block requests an interrupt.

In loop-back mode the four level bits are taken from the modem control register outputs instead of the pins. The mapping is crossed: auxiliary output 2 drives carrier, auxiliary output 1 drives ring, terminal-ready drives data-set-ready, and request-to-send drives clear-to-send. Change detection runs on whichever source is selected, so software can raise every flag by toggling control bits.

A transmit hold output tells the transmitter to stop when hardware flow control is on and the clear-to-send pin is high. The hold only takes effect after the character being sent has finished.

Top module: `uart_modem_status`

## Requirements
- R1: In normal mode, status bits 7, 6, 5 and 4 equal the inverse of carrier_n, ring_n, ready_n and send_ok_n. A pin change appears there after the third rising clock edge: two synchronizer stages plus one level register.
- R2: In loop-back mode (loop_en high), bit 7 follows mc_aux2, bit 6 follows mc_aux1, bit 5 follows mc_term_ready and bit 4 follows mc_req_send, one edge after they change.
- R3: A set change flag (status bits 3 to 0) holds its value for as long as no read strobe occurs.
- R4: A clock edge with rd_stb high clears every change flag that is not being set at that same edge.
- R5: Bit 3 sets on any change of the carrier level, bit 1 on any change of the data-set-ready level, and bit 0 on any change of the clear-to-send level.
- R6: Bit 2 sets only when the ring pin goes from low to high, which is when status bit 6 falls. It does not set when the pin falls.
- R7: irq is high exactly when irq_en is high and at least one change flag is set.
- R8: A change detected at the same edge as a read leaves its flag set.
- R9: Level changes made through the loop-back sources set the change flags by the same rules as the pins.
- R10: With flow_en high and send_ok_n high, tx_hold rises only at an edge where tx_busy is low. Once high, it stays high while the pin stays high, even if tx_busy rises again.
- R11: tx_hold falls three edges after send_ok_n goes low, or one edge after flow_en goes low.
- R12: After reset, with pins idle high, status reads 0x00, irq is low and tx_hold is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| carrier_n | input | 1 | Carrier detect pin, active low |
| ring_n | input | 1 | Ring indicator pin, active low |
| ready_n | input | 1 | Data set ready pin, active low |
| send_ok_n | input | 1 | Clear to send pin, active low |
| loop_en | input | 1 | Loop-back mode select |
| mc_aux2 | input | 1 | Control register auxiliary output 2 |
| mc_aux1 | input | 1 | Control register auxiliary output 1 |
| mc_term_ready | input | 1 | Control register terminal-ready bit |
| mc_req_send | input | 1 | Control register request-to-send bit |
| rd_stb | input | 1 | CPU read strobe for the status byte |
| irq_en | input | 1 | Modem status interrupt enable |
| flow_en | input | 1 | Hardware flow control enable |
| tx_busy | input | 1 | Transmitter is sending a character |
| status | output | 8 | Levels in bits 7..4, change flags in bits 3..0 |
| irq | output | 1 | Modem status interrupt request |
| tx_hold | output | 1 | Transmitter must not start a new character |

## Verification
The hardest case to reach is a change that lands on the very edge where a read clears the flags. The pin path cannot place an event on an exact edge without counting through the synchronizer. The bench therefore drives those cases in loop-back mode, where a control bit change and the read strobe hit the same edge. A vector table sets pairs of changed and stale flags against one read. The ring trailing-edge rule and the flow-control character boundary are then checked on the pin path with explicit latency counts.

// File: rtl/mdm_status_pkg.sv
package mdm_status_pkg;
  localparam int LINES = 4;
  localparam int IDX_SEND    = 0;
  localparam int IDX_READY   = 1;
  localparam int IDX_RING    = 2;
  localparam int IDX_CARRIER = 3;

  // Change events between consecutive level samples; ring reports falling level only
  function automatic logic [LINES-1:0] level_events(input logic [LINES-1:0] prev,
                                                    input logic [LINES-1:0] cur);
    logic [LINES-1:0] ev;
    ev = prev ^ cur;
    ev[IDX_RING] = prev[IDX_RING] & ~cur[IDX_RING];
    return ev;
  endfunction

  // Sticky flag update: new events win over a read clear
  function automatic logic [LINES-1:0] flag_update(input logic [LINES-1:0] flags,
                                                   input logic [LINES-1:0] ev,
                                                   input logic rd);
    return ev | (flags & ~{LINES{rd}});
  endfunction

  // Hold decision for the transmitter at a character boundary
  function automatic logic hold_update(input logic held, input logic enable,
                                       input logic pin_high, input logic busy);
    return enable & pin_high & (held | ~busy);
  endfunction
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] IDLE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= IDLE;
    else        stage[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[g] <= IDLE;
      else        stage[g] <= stage[g-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta
  import mdm_status_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] cur,
  input  logic             rd,
  output logic [LINES-1:0] lvl_q,
  output logic [LINES-1:0] flag_q,
  output logic [LINES-1:0] ev
);
  assign ev = level_events(lvl_q, cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      flag_q <= '0;
    end else begin
      lvl_q  <= cur;
      flag_q <= flag_update(flag_q, ev, rd);
    end
  end
endmodule

// File: rtl/mdm_flow_gate.sv
module mdm_flow_gate
  import mdm_status_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic pin_high,
  input  logic busy,
  output logic hold
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold <= 1'b0;
    else        hold <= hold_update(hold, enable, pin_high, busy);
  end
endmodule

// File: rtl/uart_modem_status.sv
module uart_modem_status
  import mdm_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       carrier_n,
  input  logic       ring_n,
  input  logic       ready_n,
  input  logic       send_ok_n,
  input  logic       loop_en,
  input  logic       mc_aux2,
  input  logic       mc_aux1,
  input  logic       mc_term_ready,
  input  logic       mc_req_send,
  input  logic       rd_stb,
  input  logic       irq_en,
  input  logic       flow_en,
  input  logic       tx_busy,
  output logic [7:0] status,
  output logic       irq,
  output logic       tx_hold
);
  logic [LINES-1:0] pins_n, pins_sync_n, looped, cur, lvl_q, flag_q, ev;

  assign pins_n = {carrier_n, ring_n, ready_n, send_ok_n};
  assign looped = {mc_aux2, mc_aux1, mc_term_ready, mc_req_send};

  mdm_sync #(.W(LINES), .STAGES(SYNC_STAGES), .IDLE('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_n), .q(pins_sync_n)
  );

  assign cur = loop_en ? looped : ~pins_sync_n;

  mdm_delta u_delta (
    .clk(clk), .rst_n(rst_n), .cur(cur), .rd(rd_stb),
    .lvl_q(lvl_q), .flag_q(flag_q), .ev(ev)
  );

  mdm_flow_gate u_flow (
    .clk(clk), .rst_n(rst_n), .enable(flow_en),
    .pin_high(pins_sync_n[IDX_SEND]), .busy(tx_busy), .hold(tx_hold)
  );

  assign status = {lvl_q, flag_q};
  assign irq    = irq_en & (|flag_q);
endmodule

// File: rtl/mdm_status_chk.sv
module mdm_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       loop_en,
  input logic [3:0] looped,
  input logic [3:0] lvl_q,
  input logic [3:0] flag_q,
  input logic [3:0] ev,
  input logic       rd_stb,
  input logic       irq_en,
  input logic       irq,
  input logic       flow_en,
  input logic       tx_busy,
  input logic       tx_hold
);
  assert_loop_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |=> lvl_q == $past(looped));

  assert_flags_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && ev == 4'b0) |=> flag_q == 4'b0);

  assert_ring_trailing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[2]) |-> ($past(lvl_q[2]) && !lvl_q[2]));

  assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && flag_q != 4'b0));

  assert_hold_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_hold) |-> !$past(tx_busy));

  assert_hold_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(flow_en) |-> !tx_hold);
endmodule

bind uart_modem_status mdm_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .looped(looped),
  .lvl_q(lvl_q), .flag_q(flag_q), .ev(ev), .rd_stb(rd_stb),
  .irq_en(irq_en), .irq(irq), .flow_en(flow_en), .tx_busy(tx_busy),
  .tx_hold(tx_hold)
);

// File: tb/tb_uart_modem_status.sv
module tb_uart_modem_status;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n;
  logic carrier_n, ring_n, ready_n, send_ok_n;
  logic loop_en, mc_aux2, mc_aux1, mc_term_ready, mc_req_send;
  logic rd_stb, irq_en, flow_en, tx_busy;
  logic [7:0] status;
  logic irq, tx_hold;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_modem_status dut (
    .clk(clk), .rst_n(rst_n), .carrier_n(carrier_n), .ring_n(ring_n),
    .ready_n(ready_n), .send_ok_n(send_ok_n), .loop_en(loop_en),
    .mc_aux2(mc_aux2), .mc_aux1(mc_aux1), .mc_term_ready(mc_term_ready),
    .mc_req_send(mc_req_send), .rd_stb(rd_stb), .irq_en(irq_en),
    .flow_en(flow_en), .tx_busy(tx_busy), .status(status), .irq(irq),
    .tx_hold(tx_hold)
  );

  // {control bits aux2,aux1,term_ready,req_send ; read ; expected status ; expected irq}
  localparam logic [13:0] VEC [12] = '{
    {4'b0000, 1'b0, 8'h00, 1'b0},
    {4'b0001, 1'b0, 8'h11, 1'b1},
    {4'b0001, 1'b1, 8'h10, 1'b0},
    {4'b0101, 1'b0, 8'h50, 1'b0},
    {4'b0001, 1'b0, 8'h14, 1'b1},
    {4'b1001, 1'b1, 8'h98, 1'b1},
    {4'b1011, 1'b0, 8'hBA, 1'b1},
    {4'b1011, 1'b1, 8'hB0, 1'b0},
    {4'b0000, 1'b0, 8'h0B, 1'b1},
    {4'b0000, 1'b1, 8'h00, 1'b0},
    {4'b1111, 1'b0, 8'hFB, 1'b1},
    {4'b1111, 1'b1, 8'hF0, 1'b0}
  };

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic read_pulse();
    rd_stb = 1'b1;
    tick(1);
    rd_stb = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {carrier_n, ring_n, ready_n, send_ok_n} = 4'hF;
    {loop_en, mc_aux2, mc_aux1, mc_term_ready, mc_req_send} = '0;
    {rd_stb, flow_en, tx_busy} = '0;
    irq_en = 1'b1;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R12 reset state
    check("R12 status", status, 8'h00);
    check("R12 irq", {7'b0, irq}, 8'h00);
    check("R12 tx_hold", {7'b0, tx_hold}, 8'h00);

    // Loop-back vector walk: R2 R4 R6 R7 R8 R9
    loop_en = 1'b1;
    for (int k = 0; k < 12; k++) begin
      {mc_aux2, mc_aux1, mc_term_ready, mc_req_send} = VEC[k][13:10];
      rd_stb = VEC[k][9];
      tick(1);
      rd_stb = 1'b0;
      check($sformatf("R2/R9/R8 vector %0d status", k), status, VEC[k][8:1]);
      check($sformatf("R7 vector %0d irq", k), {7'b0, irq}, {7'b0, VEC[k][0]});
    end

    // Back to pins, flush the mode-switch flags
    loop_en = 1'b0;
    tick(1);
    read_pulse();
    check("R4 cleared after mode switch", status, 8'h00);

    // R1 latency and level, R5 carrier flag
    carrier_n = 1'b0;
    tick(2);
    check("R1 not yet visible after two edges", status, 8'h00);
    tick(1);
    check("R1 R5 carrier asserted", status, 8'h88);

    // R6 ring: falling pin sets no flag, rising pin does
    ring_n = 1'b0;
    tick(3);
    check("R6 ring pin fall no flag", status, 8'hC8);
    ring_n = 1'b1;
    tick(3);
    check("R6 ring pin rise flag", status, 8'h8C);
    check("R7 irq with flags", {7'b0, irq}, 8'h01);
    tick(5);
    check("R3 flags held without read", status, 8'h8C);
    irq_en = 1'b0;
    tick(1);
    check("R7 irq masked", {7'b0, irq}, 8'h00);
    read_pulse();
    check("R4 read clears", status, 8'h80);
    irq_en = 1'b1;

    // R5 ready and send flags
    ready_n = 1'b0;
    send_ok_n = 1'b0;
    tick(3);
    check("R5 R1 ready and send", status, 8'hB3);
    read_pulse();
    check("R4 read clears ready and send", status, 8'hB0);

    // Flow control R10 R11
    send_ok_n = 1'b1;
    tx_busy = 1'b1;
    flow_en = 1'b1;
    tick(4);
    check("R10 no hold while character in progress", {7'b0, tx_hold}, 8'h00);
    tx_busy = 1'b0;
    tick(1);
    check("R10 hold at boundary", {7'b0, tx_hold}, 8'h01);
    tx_busy = 1'b1;
    tick(2);
    check("R10 hold stays while pin high", {7'b0, tx_hold}, 8'h01);
    send_ok_n = 1'b0;
    tick(2);
    check("R11 hold before sync latency", {7'b0, tx_hold}, 8'h01);
    tick(1);
    check("R11 hold released by pin", {7'b0, tx_hold}, 8'h00);
    send_ok_n = 1'b1;
    tx_busy = 1'b0;
    tick(3);
    check("R10 hold reasserted", {7'b0, tx_hold}, 8'h01);
    flow_en = 1'b0;
    tick(1);
    check("R11 hold released by disable", {7'b0, tx_hold}, 8'h00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule